// File: doc/BRIEF.md
# Protected Configuration Settings Bank

This block keeps an 18-byte image of device settings in a non-volatile backing array. It also keeps a run-time shadow of the four bytes that may change while the device runs. A power-on reset (`por_n`) puts factory values into the backing array. A warm reset (`rst_n`) leaves the backing array alone. After the warm reset, a load sequence copies backing bytes 0 to 3 into the shadow, one byte per clock. While the sequence runs, `busy` is high and the host port accepts nothing.

The host reaches the bank through a request stream (`req_valid`/`req_ready`) and a response stream (`rsp_valid`/`rsp_ready`). A request is read, write or unlock, and selects either the shadow or the backing image. Every request that is accepted returns exactly one response. A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low during the load, and also while a response is waiting but `rsp_ready` is low, so a stalled response holds back the next request. A response stays valid with stable data and error bit until `rsp_ready` takes it.

Writes to the backing image are gated by a lock level held in backing byte 0, bits 1:0. In one level, a write needs an earlier unlock: eight unlock bytes that match the stored password. Shadow byte 0 drives the idle level of five status pins and the serial-number enable.

Top module: `settings_vault`

## Requirements
- R1: After `rst_n` rises, `busy` stays high for exactly 4 clock edges and `req_ready` is low during that time. The sequence then copies backing bytes 0 to 3 into shadow bytes 0 to 3.
- R2: After `por_n`, the backing image holds these bytes: byte0 0x7C, byte1 0x12, byte2 0x88, byte3 0x6C, byte4 0xD8, byte5 0x04, byte6 0xDD, byte7 0x00, byte8 0x80, byte9 0x32, and bytes 10 to 17 are 0x00.
- R3: Reads use `req_op`=0. A shadow read (`req_backing`=0) of addresses 0 to 3 returns the shadow byte. A shadow read of addresses 4 to 17 returns the backing byte. Any read at an address of 18 or more returns data 0 with `rsp_err`=1.
- R4: Writes use `req_op`=1. A shadow write to addresses 0 to 3 is always accepted with `rsp_err`=0, and it is in effect from the next clock. A shadow write to an address of 4 or more returns `rsp_err`=1 and changes nothing. A shadow write never changes the backing image.
- R5: `pin_idle_hi[4:0]` equals shadow byte 0 bits 6:2, in this order from bit 4 down: UART receive LED, UART transmit LED, I2C LED, suspend, configured. A 1 means the pin idles high and is active low. `sn_enable` equals shadow byte 0 bit 7.
- R6: The lock level is backing byte 0 bits 1:0. At level 00, every backing write to addresses 0 to 17 is accepted with `rsp_err`=0.
- R7: At level 01, backing writes return `rsp_err`=1 and change nothing until an unlock succeeds. An unlock is eight requests with `req_op`=2 whose data, taken in order, all match backing bytes 10 to 17. The response to the eighth request has `rsp_err`=1 if any byte did not match, and the bank then stays locked.
- R8: A warm reset clears the unlock state and reloads the shadow from the backing image. The backing image keeps its contents.
- R9: At level 10 or 11, every backing write returns `rsp_err`=1 and changes nothing. This includes writes that try to lower the level, and holds even after a matching unlock.
- R10: A backing write to byte 8 stores bits 4:0 as zero.
- R11: Each accepted request gives one response. While `rsp_valid`=1 and `rsp_ready`=0, the response data and error bit stay stable and `req_ready` is low. `req_op`=3 is answered with `rsp_err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; loads factory values into the backing array |
| rst_n | input | 1 | Warm reset, active low; clears the shadow and the unlock state, then starts the load |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_op | input | 2 | 0 read, 1 write, 2 unlock byte, 3 invalid |
| req_backing | input | 1 | 1 selects the backing image, 0 selects the shadow |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Write data or unlock byte |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_data | output | 8 | Read data; 0 for anything other than a read |
| rsp_err | output | 1 | Request rejected or failed |
| busy | output | 1 | Load sequence in progress |
| pin_idle_hi | output | 5 | Idle level of the five status pins |
| sn_enable | output | 1 | Serial-number reporting enable |

## Verification
The hardest state to reach is the permanent lock, because it can only be entered from an unlocked state. The stimulus builds the path one step at a time. It writes a password and level 01 while the bank is unprotected, makes a failed unlock and then a matching one, and writes level 10 while unlocked. It then checks that a further write to lower the level is rejected, also after another matching unlock and after a warm reset. A stalled response stream is also produced on purpose, by holding `rsp_ready` low for several cycles.

// File: rtl/settings_pkg.sv
package settings_pkg;
  localparam int IMG_BYTES = 18;
  localparam int SH_BYTES  = 4;
  localparam int PWD_BYTES = 8;
  localparam int PWD_BASE  = 10;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int PWR_IDX   = 8;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_BAD    = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    LVL_OPEN     = 2'b00,
    LVL_PASSWORD = 2'b01,
    LVL_SEALED   = 2'b10,
    LVL_RSVD     = 2'b11
  } lock_lvl_e;

  function automatic logic [7:0] factory_byte(input int idx);
    case (idx)
      0:       return 8'h7C;
      1:       return 8'h12;
      2:       return 8'h88;
      3:       return 8'h6C;
      4:       return 8'hD8;
      5:       return 8'h04;
      6:       return 8'hDD;
      8:       return 8'h80;
      9:       return 8'h32;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sv_backing_image.sv
module sv_backing_image
  import settings_pkg::*;
#(
  parameter int N_BYTES = 18,
  parameter int W       = 8,
  parameter int AW      = 5,
  parameter int PWR_POS = 8,
  parameter logic [W-1:0] PWR_MASK = 8'hE0
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [W-1:0]       wr_data,
  output logic [N_BYTES*W-1:0] image_flat
);
  logic [W-1:0] mem_q [N_BYTES];

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    localparam logic [AW-1:0] IDX = AW'(i);
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
        mem_q[i] <= W'(factory_byte(i));
      else if (wr_en && wr_addr == IDX)
        mem_q[i] <= (i == PWR_POS) ? (wr_data & PWR_MASK) : wr_data;
    end
    assign image_flat[i*W +: W] = mem_q[i];
  end

  // R9: once the level is 1x, nothing in the backing image may change
  a_r9_sealed_frozen: assert property (@(posedge clk) disable iff (!por_n)
    mem_q[0][1] |=> $stable(image_flat));

  // R10: bits 4:0 of the power byte never hold a one after a write
  a_r10_pwr_low_zero: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && wr_addr == AW'(PWR_POS)) |=> (mem_q[PWR_POS] & ~PWR_MASK) == '0);
endmodule

// File: rtl/sv_shadow_regs.sv
module sv_shadow_regs #(
  parameter int N_SH = 4,
  parameter int W    = 8,
  parameter int AW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SH*W-1:0] src_flat,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              busy,
  output logic [N_SH*W-1:0] shadow_flat
);
  localparam int CW = (N_SH > 1) ? $clog2(N_SH) : 1;
  localparam logic [CW-1:0] LAST = CW'(N_SH - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end
  assign busy = busy_q;

  for (genvar i = 0; i < N_SH; i++) begin : g_sh
    localparam logic [CW-1:0] CI = CW'(i);
    localparam logic [AW-1:0] AI = AW'(i);
    logic [W-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sh_q <= '0;
      else if (busy_q && cnt_q == CI)
        sh_q <= src_flat[i*W +: W];
      else if (!busy_q && wr_en && wr_addr == AI)
        sh_q <= wr_data;
    end
    assign shadow_flat[i*W +: W] = sh_q;
  end

  // R1: the load runs once per reset; busy never comes back
  a_r1_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> !busy_q);

  // R1: the count only moves while loading
  a_r1_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(cnt_q));
endmodule

// File: rtl/sv_unlock_ctl.sv
module sv_unlock_ctl #(
  parameter int N_PWD = 8,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_fire,
  input  logic [W-1:0]       byte_data,
  input  logic [N_PWD*W-1:0] pwd_flat,
  output logic               unlocked,
  output logic               attempt_fail
);
  localparam int IW = (N_PWD > 1) ? $clog2(N_PWD) : 1;
  localparam logic [IW-1:0] LAST = IW'(N_PWD - 1);

  logic [IW-1:0] idx_q;
  logic          run_ok_q;
  logic          unl_q;
  logic [W-1:0]  want;
  logic          match;

  always_comb begin
    want = '0;
    for (int i = 0; i < N_PWD; i++)
      if (idx_q == IW'(i)) want = pwd_flat[i*W +: W];
  end
  assign match = (byte_data == want);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      run_ok_q <= 1'b1;
      unl_q    <= 1'b0;
    end else if (byte_fire) begin
      if (idx_q == LAST) begin
        unl_q    <= run_ok_q && match;
        idx_q    <= '0;
        run_ok_q <= 1'b1;
      end else begin
        idx_q    <= idx_q + 1'b1;
        run_ok_q <= run_ok_q && match;
      end
    end
  end

  assign unlocked     = unl_q;
  assign attempt_fail = byte_fire && (idx_q == LAST) && !(run_ok_q && match);

  // R7: the unlock can only open on the last byte of an attempt
  a_r7_open_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(byte_fire && idx_q == LAST));

  // R7: a failed attempt always leaves the bank locked
  a_r7_fail_locks: assert property (@(posedge clk) disable iff (!rst_n)
    attempt_fail |=> !unl_q);
endmodule

// File: rtl/settings_vault.sv
module settings_vault
  import settings_pkg::*;
#(
  parameter int IMG     = IMG_BYTES,
  parameter int SH      = SH_BYTES,
  parameter int NPWD    = PWD_BYTES,
  parameter int PBASE   = PWD_BASE,
  parameter int BW      = BYTE_W,
  parameter int AW      = ADDR_W,
  parameter int PWR     = PWR_IDX,
  parameter int PINS    = 5,
  parameter int PIN_LSB = 2,
  parameter int SN_BIT  = 7
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_op,
  input  logic            req_backing,
  input  logic [AW-1:0]   req_addr,
  input  logic [BW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [BW-1:0]   rsp_data,
  output logic            rsp_err,
  output logic            busy,
  output logic [PINS-1:0] pin_idle_hi,
  output logic            sn_enable
);
  localparam logic [AW-1:0] IMG_LIM = AW'(IMG);
  localparam logic [AW-1:0] SH_LIM  = AW'(SH);

  logic [IMG*BW-1:0] img_flat;
  logic [SH*BW-1:0]  sh_flat;
  logic              unlocked, attempt_fail;
  logic              accept, in_range, in_shadow, bk_allow;
  logic              sh_we, bk_we, unl_fire;
  logic [1:0]        lvl;
  logic [BW-1:0]     rd_img, rd_sh, rd_val;
  logic              err_n;
  logic              rsp_valid_q, rsp_err_q;
  logic [BW-1:0]     rsp_data_q;

  assign req_ready = !busy && (!rsp_valid_q || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign in_range  = req_addr < IMG_LIM;
  assign in_shadow = req_addr < SH_LIM;
  assign lvl       = img_flat[1:0];
  assign bk_allow  = (lvl == LVL_OPEN) || (lvl == LVL_PASSWORD && unlocked);

  assign sh_we    = accept && req_op == OP_WRITE && !req_backing && in_shadow;
  assign bk_we    = accept && req_op == OP_WRITE && req_backing && in_range && bk_allow;
  assign unl_fire = accept && req_op == OP_UNLOCK;

  sv_backing_image #(.N_BYTES(IMG), .W(BW), .AW(AW), .PWR_POS(PWR), .PWR_MASK(8'hE0)) u_bk (
    .clk(clk), .por_n(por_n), .wr_en(bk_we), .wr_addr(req_addr),
    .wr_data(req_wdata), .image_flat(img_flat));

  sv_shadow_regs #(.N_SH(SH), .W(BW), .AW(AW)) u_sh (
    .clk(clk), .rst_n(rst_n), .src_flat(img_flat[SH*BW-1:0]),
    .wr_en(sh_we), .wr_addr(req_addr), .wr_data(req_wdata),
    .busy(busy), .shadow_flat(sh_flat));

  sv_unlock_ctl #(.N_PWD(NPWD), .W(BW)) u_unl (
    .clk(clk), .rst_n(rst_n), .byte_fire(unl_fire), .byte_data(req_wdata),
    .pwd_flat(img_flat[PBASE*BW +: NPWD*BW]),
    .unlocked(unlocked), .attempt_fail(attempt_fail));

  always_comb begin
    rd_img = '0;
    rd_sh  = '0;
    for (int i = 0; i < IMG; i++)
      if (req_addr == AW'(i)) rd_img = img_flat[i*BW +: BW];
    for (int i = 0; i < SH; i++)
      if (req_addr == AW'(i)) rd_sh = sh_flat[i*BW +: BW];
    if (!in_range)                   rd_val = '0;
    else if (!req_backing && in_shadow) rd_val = rd_sh;
    else                             rd_val = rd_img;
  end

  always_comb begin
    case (req_op)
      OP_READ:   err_n = !in_range;
      OP_WRITE:  err_n = req_backing ? (!in_range || !bk_allow) : !in_shadow;
      OP_UNLOCK: err_n = attempt_fail;
      default:   err_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= err_n;
      rsp_data_q  <= (req_op == OP_READ) ? rd_val : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid   = rsp_valid_q;
  assign rsp_err     = rsp_err_q;
  assign rsp_data    = rsp_data_q;
  assign pin_idle_hi = sh_flat[PIN_LSB +: PINS];
  assign sn_enable   = sh_flat[SN_BIT];

  // R1: no request gets in while the load runs
  a_r1_hold_off: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    busy |-> !req_ready);

  // R11: a stalled response does not move
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R9: a backing write under a 1x level is answered with an error
  a_r9_sealed_err: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (accept && req_op == OP_WRITE && req_backing && lvl[1]) |=> rsp_err);

  // R3: out-of-range reads give zero data and an error
  a_r3_range_err: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (accept && req_op == OP_READ && !in_range) |=> (rsp_err && rsp_data == '0));

  // R4/R5: a shadow write to byte 0 shows at the pins on the next clock
  a_r4_shadow_pins: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (sh_we && req_addr == '0) |=> (sn_enable == $past(req_wdata[SN_BIT])));
endmodule

// File: tb/sim_settings_vault.sv
module sim_settings_vault;
  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       req_valid = 1'b0, req_backing = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic [4:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, rsp_err, busy, sn_enable;
  logic [7:0] rsp_data;
  logic [4:0] pin_idle_hi;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  settings_vault u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_backing(req_backing), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .busy(busy), .pin_idle_hi(pin_idle_hi), .sn_enable(sn_enable));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [1:0] op, input logic bk, input logic [4:0] a,
                      input logic [7:0] d, output logic [7:0] q, output logic e);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_backing = bk; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    q = rsp_data; e = rsp_err;
  endtask

  task automatic rd(input logic bk, input logic [4:0] a, output logic [7:0] q, output logic e);
    xact(2'd0, bk, a, 8'h00, q, e);
  endtask

  task automatic wr(input logic bk, input logic [4:0] a, input logic [7:0] d, output logic e);
    logic [7:0] q;
    xact(2'd1, bk, a, d, q, e);
  endtask

  task automatic unlock(input logic [7:0] bad_mask3, output logic e);
    logic [7:0] q;
    for (int i = 0; i < 8; i++)
      xact(2'd2, 1'b0, 5'd0, 8'hA0 + 8'(i) ^ ((i == 3) ? bad_mask3 : 8'h00), q, e);
  endtask

  task automatic warm_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_load_sequence;
    @(negedge clk); @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after edge 1", busy, 1);
    chk("R1 ready low while loading", req_ready, 0);
    @(negedge clk); @(negedge clk);
    chk("R1 busy after edge 3", busy, 1);
    @(negedge clk);
    chk("R1 idle after edge 4", busy, 0);
    chk("R1 ready after load", req_ready, 1);
    chk("R5 default pin idle", pin_idle_hi, 5'b11111);
    chk("R5 default serial enable", sn_enable, 0);
  endtask

  task automatic t_factory_defaults;
    logic [7:0] q; logic e;
    logic [7:0] exp_b [10] = '{8'h7C, 8'h12, 8'h88, 8'h6C, 8'hD8, 8'h04, 8'hDD, 8'h00, 8'h80, 8'h32};
    for (int i = 0; i < 10; i++) begin
      rd(1'b1, 5'(i), q, e);
      chk($sformatf("R2 backing byte %0d", i), q, exp_b[i]);
    end
    rd(1'b1, 5'd17, q, e);
    chk("R2 password byte 7", q, 8'h00);
    for (int i = 0; i < 4; i++) begin
      rd(1'b0, 5'(i), q, e);
      chk($sformatf("R1 shadow byte %0d loaded", i), q, exp_b[i]);
    end
  endtask

  task automatic t_shadow_access;
    logic [7:0] q; logic e;
    rd(1'b0, 5'd20, q, e);
    chk("R3 out-of-range err", e, 1);
    chk("R3 out-of-range data", q, 0);
    rd(1'b0, 5'd6, q, e);
    chk("R3 shadow path reads backing byte 6", q, 8'hDD);
    wr(1'b0, 5'd0, 8'h83, e);
    chk("R4 shadow write ok", e, 0);
    chk("R5 pins follow shadow", pin_idle_hi, 5'b00000);
    chk("R5 serial enable follows shadow", sn_enable, 1);
    rd(1'b0, 5'd0, q, e);
    chk("R4 shadow readback", q, 8'h83);
    rd(1'b1, 5'd0, q, e);
    chk("R4 backing byte0 untouched", q, 8'h7C);
    wr(1'b0, 5'd5, 8'h99, e);
    chk("R4 shadow write above 3 err", e, 1);
    rd(1'b1, 5'd5, q, e);
    chk("R4 byte5 unchanged", q, 8'h04);
    xact(2'd3, 1'b0, 5'd0, 8'h00, q, e);
    chk("R11 invalid op err", e, 1);
  endtask

  task automatic t_open_writes;
    logic [7:0] q; logic e;
    wr(1'b1, 5'd9, 8'h55, e);
    chk("R6 open write ok", e, 0);
    rd(1'b1, 5'd9, q, e);
    chk("R6 open write landed", q, 8'h55);
    wr(1'b1, 5'd8, 8'hFF, e);
    rd(1'b1, 5'd8, q, e);
    chk("R10 power byte low bits zero", q, 8'hE0);
    for (int i = 0; i < 8; i++) wr(1'b1, 5'(10 + i), 8'hA0 + 8'(i), e);
    wr(1'b1, 5'd0, 8'h7D, e);
    chk("R6 level to 01 ok", e, 0);
  endtask

  task automatic t_password_mode;
    logic [7:0] q; logic e;
    wr(1'b1, 5'd9, 8'h11, e);
    chk("R7 locked write err", e, 1);
    rd(1'b1, 5'd9, q, e);
    chk("R7 locked write ignored", q, 8'h55);
    unlock(8'h01, e);
    chk("R7 mismatch attempt err", e, 1);
    wr(1'b1, 5'd9, 8'h11, e);
    chk("R7 still locked after mismatch", e, 1);
    unlock(8'h00, e);
    chk("R7 matching attempt ok", e, 0);
    wr(1'b1, 5'd9, 8'h22, e);
    chk("R7 unlocked write ok", e, 0);
    rd(1'b1, 5'd9, q, e);
    chk("R7 unlocked write landed", q, 8'h22);
  endtask

  task automatic t_warm_reset;
    logic [7:0] q; logic e;
    warm_reset();
    repeat (4) @(negedge clk);
    chk("R8 load done", busy, 0);
    chk("R8 shadow reloaded pins", pin_idle_hi, 5'b11111);
    chk("R8 shadow reloaded serial", sn_enable, 0);
    rd(1'b0, 5'd0, q, e);
    chk("R8 shadow byte0 from backing", q, 8'h7D);
    rd(1'b1, 5'd9, q, e);
    chk("R8 backing kept", q, 8'h22);
    wr(1'b1, 5'd9, 8'h33, e);
    chk("R8 unlock cleared", e, 1);
  endtask

  task automatic t_backpressure;
    logic [7:0] q0; logic e;
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 2'd0; req_backing = 1'b1; req_addr = 5'd4;
    @(posedge clk); #1; req_valid = 1'b0;
    @(negedge clk);
    q0 = rsp_data;
    chk("R11 response data", q0, 8'hD8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 held valid", rsp_valid, 1);
      chk("R11 held data", rsp_data, q0);
      chk("R11 ready low while stalled", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 response drained", rsp_valid, 0);
    e = 1'b0;
  endtask

  task automatic t_sealed;
    logic [7:0] q; logic e;
    unlock(8'h00, e);
    wr(1'b1, 5'd0, 8'h7E, e);
    chk("R9 seal write accepted", e, 0);
    wr(1'b1, 5'd0, 8'h7C, e);
    chk("R9 lowering level err", e, 1);
    rd(1'b1, 5'd0, q, e);
    chk("R9 level kept", q, 8'h7E);
    unlock(8'h00, e);
    wr(1'b1, 5'd9, 8'h44, e);
    chk("R9 unlock does not open seal", e, 1);
    warm_reset();
    wr(1'b1, 5'd9, 8'h44, e);
    chk("R9 sealed after warm reset", e, 1);
    rd(1'b1, 5'd9, q, e);
    chk("R9 byte9 unchanged", q, 8'h22);
    wr(1'b0, 5'd1, 8'h5A, e);
    chk("R4 shadow write allowed when sealed", e, 0);
  endtask

  initial begin
    t_load_sequence();
    t_factory_defaults();
    t_shadow_access();
    t_open_writes();
    t_password_mode();
    t_warm_reset();
    t_backpressure();
    t_sealed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule